// File: doc/BRIEF.md
# Legacy Memory Segment Attribute Router

This block sits on the memory-routing path of a host bridge and decides, for every access that lands in the upper legacy window (0xC0000 to 0xFFFFF), whether the bridge claims the access and sends it to main memory, or lets it pass to the downstream bus for termination. Thirteen segments are covered: twelve of 16 KB spanning 0xC0000 to 0xEFFFF and one of 64 KB spanning 0xF0000 to 0xFFFFF. Each segment has its own read-enable and write-enable bit. A segment can therefore be disabled, read-only (write-protected), write-only (useful while shadowing ROM into RAM) or fully read/write. Reads and writes to one segment can go to different destinations. The same policy applies whichever agent started the access.

Software programs the policy through a byte-wide configuration port that exposes seven attribute registers at offsets 0x59 to 0x5F. Each register holds two 4-bit fields. The transaction port takes an address and a direction flag. One clock later the block returns its decision: main memory or downstream, whether the bridge is target, and whether the address fell outside the legacy window. An address outside the window gets no decision from this block, so the surrounding logic applies its default routing.

Top module: `legacy_seg_router`

## Requirements
- R1: After reset every attribute register reads 0x00. Every in-window read or write then goes downstream with rsp_to_mem=0 and rsp_target=0.
- R2: A write with cfg_we=1 to offsets 0x59..0x5F updates that register and is visible on cfg_rdata from the next cycle. At any other offset, writes are ignored and reads return 0x00.
- R3: In each register, bits [3:2] and [7:6] are reserved. They ignore writes and read as zero. Bits [3:0] of offset 0x59 control no segment and always read zero.
- R4: Within a field, bit 0 is read-enable and bit 1 is write-enable. An in-window read goes to main memory if and only if read-enable is 1. An in-window write goes to main memory if and only if write-enable is 1. All four combinations behave independently.
- R5: Segments map as follows. 0xF0000–0xFFFFF uses bits [7:4] of offset 0x59. The 16 KB segment n (n=0..11), starting at 0xC0000+n*0x4000, uses field index n+2. Field index i lives at offset 0x59+i/2, in bits [3:0] when i is even and bits [7:4] when i is odd.
- R6: An address outside 0xC0000–0xFFFFF (any upper address bit set included) returns rsp_outside=1, rsp_to_mem=0 and rsp_target=0.
- R7: The response appears exactly one cycle after txn_valid and is otherwise zero. A transaction presented in the same cycle as a configuration write uses the attributes from before that write.
- R8: For every in-window access, rsp_target equals rsp_to_mem and rsp_outside is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| txn_valid | input | 1 | Transaction presented this cycle |
| txn_addr | input | 32 | Transaction byte address |
| txn_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Decision valid (one cycle after txn_valid) |
| rsp_to_mem | output | 1 | Access is claimed and sent to main memory |
| rsp_target | output | 1 | Block acts as target for the access |
| rsp_outside | output | 1 | Address is outside the legacy window |

## Verification
A corrupted attribute bit shows up in two places. It shows on cfg_rdata as soon as the register is read back. It also shows on the very next decision for the affected segment and direction, one cycle after the access. A wrong segment index makes a neighbouring segment's policy appear at a segment edge, so the sweep probes the first, middle and last byte of every segment under four rotating attribute patterns. A stale or early attribute appears only when a configuration write and a transaction share a cycle, so that case is driven on its own.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   typedef struct packed {
      logic wr_en;
      logic rd_en;
   } seg_attr_t;

   localparam int FIELD_BITS = 4;
   localparam int ATTR_BITS  = 2;
endpackage

// File: rtl/lsr_attr_bank.sv
module lsr_attr_bank #(
   parameter int                CFG_AW   = 8,
   parameter logic [CFG_AW-1:0] REG_BASE = 8'h59,
   parameter int                NUM_REGS = 7,
   parameter bit                RD_REG   = 1'b0,
   localparam int               NUM_FLD  = 2 * NUM_REGS
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_we,
   input  logic [CFG_AW-1:0]                      cfg_addr,
   input  logic [7:0]                             cfg_wdata,
   output logic [7:0]                             cfg_rdata,
   output logic [NUM_FLD*lsr_pkg::ATTR_BITS-1:0]  attr_vec
);
   import lsr_pkg::*;

   logic [CFG_AW-1:0] rel_off;
   logic              off_hit;
   logic [7:0]        rd_comb;
   logic [1:0]        unused_rsv;

   assign rel_off    = cfg_addr - REG_BASE;
   assign off_hit    = (cfg_addr >= REG_BASE) && (rel_off < CFG_AW'(NUM_REGS));
   assign unused_rsv = {^cfg_wdata[7:6], ^cfg_wdata[3:2]};

   // Field 0 has no segment: tied to zero. Others hold two live bits.
   assign attr_vec[ATTR_BITS-1:0] = '0;

   for (genvar f = 1; f < NUM_FLD; f++) begin : g_fld
      localparam int REG_IX = f / 2;
      localparam int NIB_LO = (f % 2) * FIELD_BITS;
      seg_attr_t fld_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            fld_q <= '0;
         else if (cfg_we && off_hit && (rel_off == CFG_AW'(REG_IX)))
            fld_q <= cfg_wdata[NIB_LO +: ATTR_BITS];
      end

      assign attr_vec[f*ATTR_BITS +: ATTR_BITS] = fld_q;

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == REG_BASE + CFG_AW'(REG_IX))
         |=> (fld_q == $past(cfg_wdata[NIB_LO +: ATTR_BITS]))); // R2
   end

   always_comb begin
      rd_comb = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (off_hit && rel_off == CFG_AW'(r))
            rd_comb = {2'b00, attr_vec[(2*r+1)*ATTR_BITS +: ATTR_BITS],
                       2'b00, attr_vec[(2*r)*ATTR_BITS +: ATTR_BITS]};
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) cfg_rdata <= '0;
         else        cfg_rdata <= rd_comb;
      end
   end else begin : g_rd_comb
      assign cfg_rdata = rd_comb;
   end

   AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & 8'hCC) == 8'h00); // R3
   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!RD_REG && !off_hit) |-> (cfg_rdata == 8'h00)); // R2
endmodule

// File: rtl/lsr_seg_decode.sv
module lsr_seg_decode #(
   parameter int  ADDR_W = 32,
   localparam int FIX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win,
   output logic [FIX_W-1:0]  fld_ix
);
   logic upper_clear;
   logic unused_low;

   if (ADDR_W > 20) begin : g_wide
      assign upper_clear = (addr[ADDR_W-1:20] == '0);
   end else begin : g_narrow
      assign upper_clear = 1'b1;
   end

   assign unused_low = ^addr[13:0];
   assign in_win     = upper_clear && (addr[19:18] == 2'b11);

   // 0xF0000-0xFFFFF -> field 1; 16 KB segment n of 0xC0000-0xEFFFF -> field n+2
   always_comb begin
      if (addr[17:16] == 2'b11) fld_ix = FIX_W'(1);
      else                      fld_ix = FIX_W'(2) + FIX_W'(addr[17:14]);
   end
endmodule

// File: rtl/lsr_route.sv
module lsr_route (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               txn_valid,
   input  logic               txn_write,
   input  logic               in_win,
   input  lsr_pkg::seg_attr_t attr,
   output logic               rsp_valid,
   output logic               rsp_to_mem,
   output logic               rsp_target,
   output logic               rsp_outside
);
   logic claim;

   assign claim = in_win && (txn_write ? attr.wr_en : attr.rd_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_to_mem  <= 1'b0;
         rsp_target  <= 1'b0;
         rsp_outside <= 1'b0;
      end else begin
         rsp_valid   <= txn_valid;
         rsp_to_mem  <= txn_valid && claim;
         rsp_target  <= txn_valid && claim;
         rsp_outside <= txn_valid && !in_win;
      end
   end

   AST_OUTSIDE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_outside |-> (!rsp_to_mem && !rsp_target)); // R6
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> rsp_valid); // R7
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> (!rsp_valid && !rsp_to_mem && !rsp_outside)); // R7
endmodule

// File: rtl/legacy_seg_router.sv
module legacy_seg_router #(
   parameter int                ADDR_W   = 32,
   parameter int                CFG_AW   = 8,
   parameter logic [CFG_AW-1:0] REG_BASE = 8'h59,
   parameter int                NUM_REGS = 7,
   parameter bit                RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              txn_write,
   output logic              rsp_valid,
   output logic              rsp_to_mem,
   output logic              rsp_target,
   output logic              rsp_outside
);
   import lsr_pkg::*;

   localparam int NUM_FLD = 2 * NUM_REGS;
   localparam int FIX_W   = 4;

   if (ADDR_W < 20) begin : g_chk_aw
      $error("ADDR_W must cover the 1 MB legacy window");
   end
   if (NUM_REGS != 7) begin : g_chk_regs
      $error("segment map needs exactly seven attribute registers");
   end
   if (int'(REG_BASE) + NUM_REGS > (1 << CFG_AW)) begin : g_chk_base
      $error("attribute registers overflow the configuration space");
   end

   logic [NUM_FLD*ATTR_BITS-1:0] attr_vec;
   logic                         in_win;
   logic [FIX_W-1:0]             fld_ix;
   seg_attr_t                    sel_attr;

   lsr_attr_bank #(
      .CFG_AW(CFG_AW), .REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS), .RD_REG(RD_REG)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_vec(attr_vec)
   );

   lsr_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(txn_addr), .in_win(in_win), .fld_ix(fld_ix)
   );

   assign sel_attr = attr_vec[fld_ix*ATTR_BITS +: ATTR_BITS];

   lsr_route u_route (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_write(txn_write),
      .in_win(in_win), .attr(sel_attr), .rsp_valid(rsp_valid),
      .rsp_to_mem(rsp_to_mem), .rsp_target(rsp_target), .rsp_outside(rsp_outside)
   );

   AST_DECODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> (fld_ix >= FIX_W'(1) && fld_ix < FIX_W'(NUM_FLD))); // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !rsp_to_mem && !rsp_target)); // R1
endmodule

// File: tb/legacy_seg_router_tb.sv
module legacy_seg_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_write = 1'b0;
   logic        rsp_valid, rsp_to_mem, rsp_target, rsp_outside;

   int n_chk = 0;
   int n_fail = 0;
   logic [1:0] shadow [14];

   always #5 clk = ~clk;

   legacy_seg_router u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
      .txn_addr(txn_addr), .txn_write(txn_write), .rsp_valid(rsp_valid),
      .rsp_to_mem(rsp_to_mem), .rsp_target(rsp_target), .rsp_outside(rsp_outside)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [7:0] exp_reg(int r);
      logic [1:0] lo;
      lo = (r == 0) ? 2'b00 : shadow[2*r];
      return {2'b00, shadow[2*r+1], 2'b00, lo};
   endfunction

   task automatic cfg_check(logic [7:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(req, {24'h0, cfg_rdata}, {24'h0, exp}, $sformatf("cfg read %0h", a));
   endtask

   // Returns response bits {valid,to_mem,target,outside} one cycle later.
   task automatic txn(logic [31:0] a, logic wr, output logic [3:0] rsp);
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a; txn_write = wr;
      @(negedge clk);
      txn_valid = 1'b0;
      rsp = {rsp_valid, rsp_to_mem, rsp_target, rsp_outside};
   endtask

   function automatic logic [3:0] exp_rsp(logic [31:0] a, logic wr);
      int f;
      logic c;
      if (a < 32'hC0000 || a > 32'hFFFFF) return 4'b1001;
      f = (a >= 32'hF0000) ? 1 : 2 + int'((a - 32'hC0000) >> 14);
      c = wr ? shadow[f][1] : shadow[f][0];
      return {1'b1, c, c, 1'b0};
   endfunction

   task automatic txn_check(logic [31:0] a, logic wr, string req);
      logic [3:0] r;
      txn(a, wr, r);
      check(req, {28'h0, r}, {28'h0, exp_rsp(a, wr)}, $sformatf("txn %0h wr=%0b", a, wr));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [3:0] r;
      for (int i = 0; i < 14; i++) shadow[i] = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", {31'h0, rsp_valid}, 32'h0, "rsp_valid after reset");
      for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), 8'h00, "R1");
      txn_check(32'hC0000, 1'b0, "R1");
      txn_check(32'hF8000, 1'b1, "R1");

      // R4 R5 R3 R8: rotating attribute patterns, sweep all segments
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 7; k++) begin
            logic [1:0] clo, chi;
            clo = 2'((2*k + p) % 4);
            chi = 2'((2*k + 1 + p) % 4);
            if (k != 0) shadow[2*k] = clo;
            shadow[2*k+1] = chi;
            cfg_write(8'(8'h59 + k), {2'b11, chi, 2'b10, clo});
         end
         for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), exp_reg(k), "R3");
         for (int n = 0; n < 13; n++) begin
            logic [31:0] base, size;
            base = (n == 12) ? 32'hF0000 : 32'hC0000 + 32'(n) * 32'h4000;
            size = (n == 12) ? 32'h10000 : 32'h4000;
            for (int w = 0; w < 2; w++) begin
               txn_check(base, w[0], "R5");
               txn_check(base + size / 2, w[0], "R4");
               txn_check(base + size - 1, w[0], "R8");
            end
         end
      end

      // R6: outside the window
      txn_check(32'h00000000, 1'b0, "R6");
      txn_check(32'h000A0000, 1'b1, "R6");
      txn_check(32'h000BFFFF, 1'b0, "R6");
      txn_check(32'h00100000, 1'b1, "R6");
      txn_check(32'h800F0000, 1'b0, "R6");

      // R2: unmapped offsets ignore writes and read zero
      cfg_write(8'h58, 8'hFF);
      cfg_write(8'h60, 8'hFF);
      cfg_check(8'h58, 8'h00, "R2");
      cfg_check(8'h60, 8'h00, "R2");
      for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), exp_reg(k), "R2");

      // R2: write visible next cycle
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'h5C; cfg_wdata = 8'h31;
      @(negedge clk);
      cfg_we = 1'b0;
      shadow[6] = 2'b01; shadow[7] = 2'b11;
      #1;
      check("R2", {24'h0, cfg_rdata}, 32'h31, "readback next cycle");

      // R7: same-cycle write and transaction uses old attributes
      cfg_write(8'h5A, 8'h03);          // field 2 = read/write
      shadow[2] = 2'b11; shadow[3] = 2'b00;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h00;
      txn_valid = 1'b1; txn_addr = 32'hC1000; txn_write = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; txn_valid = 1'b0;
      r = {rsp_valid, rsp_to_mem, rsp_target, rsp_outside};
      check("R7", {28'h0, r}, 32'hE, "txn alongside cfg write");
      shadow[2] = 2'b00;
      @(negedge clk);
      check("R7", {31'h0, rsp_valid}, 32'h0, "rsp_valid idle");
      txn_check(32'hC1000, 1'b0, "R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule